// File: doc/BRIEF.md
# Multicycle Multiply-Divide Unit

This unit sits next to a 32-bit integer core and carries out multiply, multiply-accumulate and divide work on a private HI/LO register pair. The core sends one command at a time on a valid/ready channel. Each command carries an operation code and two operands. Multiplies finish after a short fixed latency. Divides use a restoring iteration of one quotient bit per clock, so they take much longer. Writes to HI or LO take effect at once.

The core reads HI or LO through a second valid/ready channel. Both channels apply back-pressure the same way. `cmd_ready` and `rd_ready` drop while an operation is in flight. A command that is offered during that time is simply not taken, and the core must hold it or drop it. A read is served only in a cycle where `rd_ready` is high, so reads of HI/LO stall until the result has been written.

The three-operand multiply does not change HI/LO. It returns its low result word on `res_data` with a one-cycle `res_valid` pulse. This output has no ready signal, so the core must capture it in that cycle.

Signed accumulates can run in a saturating mode. An overflow flag records any signed accumulate overflow and stays set until reset.

Top module: `mdu_top`

## Requirements
- R1: Op code 1 (signed) and op code 2 (unsigned) place the 64-bit product of `cmd_a` and `cmd_b` in HI:LO. `busy` stays high for exactly 4 cycles after the accepting edge.
- R2: Op codes 3 and 4 (signed and unsigned add) add the product to HI:LO. Op codes 5 and 6 (signed and unsigned subtract) subtract the product from HI:LO. `busy` stays high for 5 cycles. Unsigned forms wrap modulo 2^64 and never set the overflow flag.
- R3: When a signed accumulate (op 3 or 5) overflows 64 bits, `ovf_flag` is set and stays set until reset. If `sat_en` was high when the command was accepted, HI:LO clamps to 0x7FFF_FFFF_FFFF_FFFF or 0x8000_0000_0000_0000. Otherwise HI:LO wraps.
- R4: Op code 7 (signed) pulses `res_valid` for one cycle, carrying the low 32 bits of the product on `res_data`, in the cycle after `busy` falls. `busy` lasts 4 cycles, and HI and LO are left unchanged.
- R5: Op code 9 (unsigned divide) writes the quotient to LO and the remainder to HI. `busy` lasts 34 cycles.
- R6: Op code 8 (signed divide) truncates toward zero, and the remainder takes the sign of the dividend. `busy` lasts 35 cycles.
- R7: A divide by zero finishes in the same 34 or 35 cycles and returns the unit to idle.
- R8: Op code 10 loads `cmd_a` into HI and op code 11 loads `cmd_a` into LO, both at the accepting edge, without raising `busy`.
- R9: `cmd_ready` is the inverse of `busy`. A command offered while busy is ignored: HI/LO and the latency of the running operation are unaffected.
- R10: `rd_ready` is low while busy. When `rd_valid` and `rd_ready` are both high, `rd_data` shows HI for `rd_sel`=1 and LO for `rd_sel`=0. Otherwise `rd_data` is zero.
- R11: After reset, HI and LO are zero, `busy` and `ovf_flag` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 4 | Operation code |
| cmd_a | input | 32 | First operand / dividend / HI-LO write data |
| cmd_b | input | 32 | Second operand / divisor |
| sat_en | input | 1 | Saturating mode for signed accumulates |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read can be served this cycle |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_data | output | 32 | Read data |
| res_valid | output | 1 | Three-operand multiply result pulse |
| res_data | output | 32 | Three-operand multiply low word |
| busy | output | 1 | Operation in flight |
| ovf_flag | output | 1 | Sticky signed-accumulate overflow |

## Verification
Some properties are checked on every cycle. These are the exact busy length of each operation class, HI/LO holding still while an operation is in flight, the one-cycle shape of the multiply result pulse, the overflow flag never clearing, immediate HI/LO writes, and the divider's iteration bound. Only the bench's scenarios can show the arithmetic results: signed versus unsigned products, accumulate wrap and clamp values, and quotient and remainder signs. The bench also shows that a command offered while busy leaves no trace.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_MULT  = 4'd1,
    OP_MULTU = 4'd2,
    OP_MADD  = 4'd3,
    OP_MADDU = 4'd4,
    OP_MSUB  = 4'd5,
    OP_MSUBU = 4'd6,
    OP_MUL   = 4'd7,
    OP_DIV   = 4'd8,
    OP_DIVU  = 4'd9,
    OP_MTHI  = 4'd10,
    OP_MTLO  = 4'd11
  } mdu_op_e;

  function automatic logic op_is_mul(mdu_op_e op);
    return op inside {OP_MULT, OP_MULTU, OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU, OP_MUL};
  endfunction

  function automatic logic op_is_acc(mdu_op_e op);
    return op inside {OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU};
  endfunction

  function automatic logic op_is_signed_mul(mdu_op_e op);
    return op inside {OP_MULT, OP_MADD, OP_MSUB, OP_MUL};
  endfunction
endpackage

// File: rtl/mdu_mul_acc.sv
module mdu_mul_acc #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           sgn_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [2*W-1:0] acc_i,
  input  logic           sub_i,
  input  logic           acc_sgn_i,
  input  logic           sat_i,
  output logic [2*W-1:0] prod_o,
  output logic [2*W-1:0] sum_o,
  output logic           ovf_o
);
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] SMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] SMIN = {1'b1, {(PW-1){1'b0}}};

  logic signed [W:0]      ax, bx;
  logic signed [PW+1:0]   full;
  logic [PW-1:0]          prod_q;
  logic [PW:0]            ext_acc, ext_prod, raw;

  assign ax   = {sgn_i & a_i[W-1], a_i};
  assign bx   = {sgn_i & b_i[W-1], b_i};
  assign full = ax * bx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prod_q <= '0;
    else if (load_i) prod_q <= full[PW-1:0];
  end

  assign ext_acc  = {acc_sgn_i & acc_i[PW-1], acc_i};
  assign ext_prod = {acc_sgn_i & prod_q[PW-1], prod_q};
  assign raw      = sub_i ? (ext_acc - ext_prod) : (ext_acc + ext_prod);

  always_comb begin
    ovf_o = acc_sgn_i & (raw[PW] ^ raw[PW-1]);
    if (ovf_o && sat_i) sum_o = raw[PW] ? SMIN : SMAX;
    else                sum_o = raw[PW-1:0];
  end

  assign prod_o = prod_q;

  a_r1_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(prod_o));
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int IW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          qneg_q, rneg_q;
  logic [IW-1:0] iter_q;
  logic [W:0]    r_sh, diff;
  logic          ge;

  assign r_sh = {rem_q, quo_q[W-1]};
  assign diff = r_sh - {1'b0, dvs_q};
  assign ge   = ~diff[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= '0;
      qneg_q <= 1'b0; rneg_q <= 1'b0;
      iter_q <= IW'(W);
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= (sgn_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
      dvs_q  <= (sgn_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;
      qneg_q <= sgn_i & (a_i[W-1] ^ b_i[W-1]);
      rneg_q <= sgn_i & a_i[W-1];
      iter_q <= '0;
    end else if (iter_q != IW'(W)) begin
      rem_q  <= ge ? diff[W-1:0] : r_sh[W-1:0];
      quo_q  <= {quo_q[W-2:0], ge};
      iter_q <= iter_q + 1'b1;
    end
  end

  assign quo_o = qneg_q ? (~quo_q + 1'b1) : quo_q;
  assign rem_o = rneg_q ? (~rem_q + 1'b1) : rem_q;

  a_r5_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= IW'(W));
  a_r5_iter_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> iter_q == '0);
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int W       = 32,
  parameter int MUL_LAT = 4,
  parameter int ACC_LAT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  input  logic         sat_en,
  input  logic         rd_valid,
  output logic         rd_ready,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         busy,
  output logic         ovf_flag
);
  localparam int DIVU_LAT = W + 2;
  localparam int DIV_LAT  = W + 3;
  localparam int CW       = $clog2(W + ACC_LAT + MUL_LAT + 4);

  mdu_op_e       op_in, op_q;
  logic          busy_q, sat_q, ovf_q, res_valid_q;
  logic [CW-1:0] cnt_q, lat;
  logic [W-1:0]  hi_q, lo_q, res_q;
  logic          accept, mul_start, div_start;
  logic [2*W-1:0] prod, acc_sum;
  logic          acc_ovf;
  logic [W-1:0]  quo, rem;

  assign op_in     = mdu_op_e'(cmd_op);
  assign accept    = cmd_valid && !busy_q;
  assign mul_start = accept && op_is_mul(op_in);
  assign div_start = accept && (op_in inside {OP_DIV, OP_DIVU});

  always_comb begin
    case (op_in)
      OP_MULT, OP_MULTU, OP_MUL:           lat = CW'(MUL_LAT);
      OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU: lat = CW'(ACC_LAT);
      OP_DIVU:                              lat = CW'(DIVU_LAT);
      OP_DIV:                               lat = CW'(DIV_LAT);
      default:                              lat = CW'(1);
    endcase
  end

  mdu_mul_acc #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load_i(mul_start),
    .sgn_i(op_is_signed_mul(op_in)), .a_i(cmd_a), .b_i(cmd_b),
    .acc_i({hi_q, lo_q}), .sub_i(op_q inside {OP_MSUB, OP_MSUBU}),
    .acc_sgn_i(op_q inside {OP_MADD, OP_MSUB}), .sat_i(sat_q),
    .prod_o(prod), .sum_o(acc_sum), .ovf_o(acc_ovf)
  );

  mdu_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_start),
    .sgn_i(op_in == OP_DIV), .a_i(cmd_a), .b_i(cmd_b),
    .quo_o(quo), .rem_o(rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; op_q <= OP_NONE; sat_q <= 1'b0;
      hi_q <= '0; lo_q <= '0; ovf_q <= 1'b0;
      res_valid_q <= 1'b0; res_q <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (accept) begin
        case (op_in)
          OP_MTHI: hi_q <= cmd_a;
          OP_MTLO: lo_q <= cmd_a;
          OP_MULT, OP_MULTU, OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU,
          OP_MUL, OP_DIV, OP_DIVU: begin
            busy_q <= 1'b1;
            cnt_q  <= lat - 1'b1;
            op_q   <= op_in;
            sat_q  <= sat_en;
          end
          default: ;
        endcase
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          case (op_q)
            OP_MULT, OP_MULTU: {hi_q, lo_q} <= prod;
            OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU: begin
              {hi_q, lo_q} <= acc_sum;
              if (acc_ovf) ovf_q <= 1'b1;
            end
            OP_MUL: begin
              res_valid_q <= 1'b1;
              res_q       <= prod[W-1:0];
            end
            OP_DIV, OP_DIVU: begin
              hi_q <= rem;
              lo_q <= quo;
            end
            default: ;
          endcase
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cmd_ready = !busy_q;
  assign rd_ready  = !busy_q;
  assign rd_data   = (rd_valid && !busy_q) ? (rd_sel ? hi_q : lo_q) : '0;
  assign res_valid = res_valid_q;
  assign res_data  = res_q;
  assign busy      = busy_q;
  assign ovf_flag  = ovf_q;

  // Checker state: counts busy cycles of the current operation.
  logic [CW-1:0] blen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     blen_q <= '0;
    else if (accept)                blen_q <= CW'(1);
    else if (busy_q && cnt_q != '0) blen_q <= blen_q + 1'b1;
  end

  a_r1_mult_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && op_q inside {OP_MULT, OP_MULTU}) |-> blen_q == CW'(MUL_LAT));
  a_r2_acc_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && op_is_acc(op_q)) |-> blen_q == CW'(ACC_LAT));
  a_r5_divu_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && op_q == OP_DIVU) |-> blen_q == CW'(DIVU_LAT));
  a_r6_div_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && op_q == OP_DIV) |-> blen_q == CW'(DIV_LAT));
  a_r9_hilo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> ($stable(hi_q) && $stable(lo_q)));
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  a_r4_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_q |=> !res_valid_q);
  a_r4_res_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_q |-> ($fell(busy_q) && op_q == OP_MUL));
  a_r8_mthi_now: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_in == OP_MTHI) |=> (!busy_q && hi_q == $past(cmd_a)));
endmodule

// File: tb/mdu_top_test.sv
module mdu_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = 4'd0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        sat_en = 1'b0;
  logic        rd_valid = 1'b0, rd_ready, rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        res_valid;
  logic [31:0] res_data;
  logic        busy, ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          last_cyc;
  logic        last_rv;
  logic [31:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_top uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .sat_en(sat_en),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel), .rd_data(rd_data),
    .res_valid(res_valid), .res_data(res_data), .busy(busy), .ovf_flag(ovf_flag)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic sat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b; sat_en = sat;
    @(negedge clk);
    cmd_valid = 1'b0; sat_en = 1'b0;
    last_cyc = 0;
    while (busy) begin
      last_cyc++;
      @(negedge clk);
    end
    last_rv = res_valid;
    last_rd = res_data;
  endtask

  task automatic read_hilo(output logic [63:0] v);
    @(negedge clk);
    rd_valid = 1'b1; rd_sel = 1'b1; #1 v[63:32] = rd_data;
    rd_sel = 1'b0; #1 v[31:0] = rd_data;
    rd_valid = 1'b0;
  endtask

  task automatic set_hilo(input logic [63:0] v);
    run_op(4'd10, v[63:32], '0, 1'b0);
    run_op(4'd11, v[31:0], '0, 1'b0);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R11 busy", {63'b0, busy}, 64'd0);
    check("R11 ovf_flag", {63'b0, ovf_flag}, 64'd0);
    check("R11 cmd_ready", {63'b0, cmd_ready}, 64'd1);
    read_hilo(v);
    check("R11 hilo", v, 64'd0);
  endtask

  task automatic t_mthi_mtlo();
    logic [63:0] v;
    run_op(4'd10, 32'h1234_5678, 32'h0, 1'b0);
    check("R8 MTHI no busy", 64'(last_cyc), 64'd0);
    run_op(4'd11, 32'h9abc_def0, 32'h0, 1'b0);
    check("R8 MTLO no busy", 64'(last_cyc), 64'd0);
    read_hilo(v);
    check("R8 R10 hi/lo read", v, 64'h1234_5678_9abc_def0);
    @(negedge clk); rd_valid = 1'b0; rd_sel = 1'b1; #1;
    check("R10 no read data", {32'b0, rd_data}, 64'd0);
  endtask

  task automatic t_mult();
    logic [63:0] v;
    logic [31:0] a = 32'hFFFF_FFFE, b = 32'd3;
    run_op(4'd1, a, b, 1'b0);
    check("R1 MULT cycles", 64'(last_cyc), 64'd4);
    read_hilo(v);
    check("R1 MULT value", v, 64'(longint'($signed(a)) * longint'($signed(b))));
    run_op(4'd2, a, b, 1'b0);
    check("R1 MULTU cycles", 64'(last_cyc), 64'd4);
    read_hilo(v);
    check("R1 MULTU value", v, {32'b0, a} * {32'b0, b});
    run_op(4'd1, 32'h8000_0000, 32'h8000_0000, 1'b0);
    read_hilo(v);
    check("R1 MULT min*min", v, 64'h4000_0000_0000_0000);
  endtask

  task automatic t_acc();
    logic [63:0] v;
    set_hilo(64'd100);
    run_op(4'd3, 32'hFFFF_FFFF, 32'd5, 1'b0);
    check("R2 MADD cycles", 64'(last_cyc), 64'd5);
    read_hilo(v);
    check("R2 MADD value", v, 64'd95);
    run_op(4'd5, 32'd7, 32'd3, 1'b0);
    read_hilo(v);
    check("R2 MSUB value", v, 64'd74);
    set_hilo(64'hFFFF_FFFF_0000_0000);
    run_op(4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    read_hilo(v);
    check("R2 MADDU value", v, 64'hFFFF_FFFF_0000_0000 + 64'hFFFF_FFFE_0000_0001);
    set_hilo(64'd0);
    run_op(4'd6, 32'd1, 32'd1, 1'b0);
    check("R2 MSUBU cycles", 64'(last_cyc), 64'd5);
    read_hilo(v);
    check("R2 MSUBU wrap", v, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R2 unsigned no ovf", {63'b0, ovf_flag}, 64'd0);
  endtask

  task automatic t_mul3();
    logic [63:0] v;
    set_hilo(64'hAAAA_5555_0F0F_F0F0);
    run_op(4'd7, 32'd7, 32'hFFFF_FFFD, 1'b0);
    check("R4 MUL cycles", 64'(last_cyc), 64'd4);
    check("R4 res_valid", {63'b0, last_rv}, 64'd1);
    check("R4 res_data", {32'b0, last_rd}, {32'b0, 32'hFFFF_FFEB});
    @(negedge clk);
    check("R4 pulse one cycle", {63'b0, res_valid}, 64'd0);
    read_hilo(v);
    check("R4 hilo unchanged", v, 64'hAAAA_5555_0F0F_F0F0);
  endtask

  task automatic t_div();
    logic [63:0] v;
    run_op(4'd9, 32'd100, 32'd7, 1'b0);
    check("R5 DIVU cycles", 64'(last_cyc), 64'd34);
    read_hilo(v);
    check("R5 DIVU rem/quo", v, {32'd2, 32'd14});
    run_op(4'd9, 32'hFFFF_FFFF, 32'd16, 1'b0);
    read_hilo(v);
    check("R5 DIVU large", v, {32'd15, 32'h0FFF_FFFF});
    run_op(4'd8, -32'sd7, 32'sd2, 1'b0);
    check("R6 DIV cycles", 64'(last_cyc), 64'd35);
    read_hilo(v);
    check("R6 DIV neg dividend", v, {32'hFFFF_FFFF, 32'hFFFF_FFFD});
    run_op(4'd8, 32'sd7, -32'sd2, 1'b0);
    read_hilo(v);
    check("R6 DIV neg divisor", v, {32'd1, 32'hFFFF_FFFD});
    run_op(4'd9, 32'd55, 32'd0, 1'b0);
    check("R7 DIVU by zero cycles", 64'(last_cyc), 64'd34);
    run_op(4'd8, 32'd55, 32'd0, 1'b0);
    check("R7 DIV by zero cycles", 64'(last_cyc), 64'd35);
    check("R7 idle after", {63'b0, cmd_ready}, 64'd1);
  endtask

  task automatic t_ignored();
    logic [63:0] v;
    int cyc = 0;
    set_hilo(64'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'd1; cmd_a = 32'd3; cmd_b = 32'd5;
    @(negedge clk);
    check("R9 cmd_ready low when busy", {63'b0, cmd_ready}, 64'd0);
    check("R10 rd_ready low when busy", {63'b0, rd_ready}, 64'd0);
    cmd_op = 4'd11; cmd_a = 32'hDEAD;
    while (busy) begin
      cyc++;
      if (cyc == 2) cmd_op = 4'd10;
      if (cyc == 3) cmd_op = 4'd9;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check("R9 latency unchanged", 64'(cyc), 64'd4);
    read_hilo(v);
    check("R9 ignored commands", v, 64'd15);
  endtask

  task automatic t_sat();
    logic [63:0] v;
    set_hilo(64'h7FFF_FFFF_FFFF_FFF0);
    run_op(4'd3, 32'd1, 32'd1, 1'b1);
    check("R3 no ovf in range", {63'b0, ovf_flag}, 64'd0);
    run_op(4'd3, 32'h10, 32'd1, 1'b1);
    read_hilo(v);
    check("R3 clamp max", v, 64'h7FFF_FFFF_FFFF_FFFF);
    check("R3 flag set", {63'b0, ovf_flag}, 64'd1);
    set_hilo(64'h8000_0000_0000_0000);
    run_op(4'd5, 32'd1, 32'd1, 1'b1);
    read_hilo(v);
    check("R3 clamp min", v, 64'h8000_0000_0000_0000);
    set_hilo(64'h7FFF_FFFF_FFFF_FFF0);
    run_op(4'd3, 32'h10, 32'd1, 1'b0);
    read_hilo(v);
    check("R3 wrap without sat", v, 64'h8000_0000_0000_0000);
    run_op(4'd1, 32'd2, 32'd2, 1'b0);
    check("R3 flag sticky", {63'b0, ovf_flag}, 64'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mthi_mtlo();
    t_mult();
    t_acc();
    t_mul3();
    t_div();
    t_ignored();
    t_sat();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule